// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the five status flags of a small processor core and produces the result of an 8-bit ALU operation. On each cycle the ALU result is formed combinationally from two operands, an operation code and the current carry flag. When the execute strobe is high, the zero, digit-carry and carry flags take the values that this operation defines. Subtraction is carried out as addition of the two's complement, so both carry flags read as "no borrow". The two rotate operations pass through the carry flag.

Two power-management flags, time-out and power-down, are held by a four-state machine. Its state is the flag pair {time-out, power-down}. The states are `PM_AWAKE` (11), `PM_DOZING` (10), `PM_EXPIRED` (01) and `PM_EXP_DOZING` (00). It moves between them on single-cycle event pulses: power-up, watchdog clear, sleep and watchdog time-out. A time-out clears time-out, and power-up, watchdog clear or sleep set it. Sleep clears power-down, and power-up or watchdog clear set it. When several events arrive in the same cycle, the next state is chosen by the priorities in R8 and R9. With no event, every state stays where it is. Software can load the three arithmetic flags directly. The watchdog itself, the instruction decoder and the rest of the datapath lie outside the block.

Top module: `alu_flag_reg`

## Requirements
- R1: While reset (rst_n low) is asserted, `status` reads 8'h18: time-out = 1, power-down = 1, zero, digit carry and carry = 0.
- R2: `status` layout is bit4 time-out, bit3 power-down, bit2 zero, bit1 digit carry, bit0 carry, and bits 7..5 always read 0. When `sw_we` is high, bits 2..0 take `sw_wdata[2..0]` on the next edge. `sw_wdata[7..3]` has no effect. A software write wins over an ALU update in the same cycle.
- R3: Op code 0 (add): `result` = (A+B) mod 256. Carry is the carry out of bit 7 and digit carry is the carry out of bit 3.
- R4: Op code 1 (subtract): `result` = (A−B) mod 256, formed as A + ~B + 1. Carry is 1 exactly when A ≥ B, and digit carry is 1 exactly when A[3:0] ≥ B[3:0].
- R5: On add, subtract and the logic ops, zero becomes 1 when `result` is 0 and 0 otherwise. Rotates leave zero unchanged unless parameter ROT_SETS_Z is 1 (default 0).
- R6: Op code 2 (rotate right through carry) gives `result` = {C, A[7:1]} and carry ← A[0]. Op code 3 (rotate left through carry) gives `result` = {A[6:0], C} and carry ← A[7]. Rotates leave digit carry unchanged.
- R7: Op codes 4 AND, 5 OR, 6 XOR and 7 PASS (result = A) leave carry and digit carry unchanged.
- R8: Time-out is cleared by `ev_wdt_tmo`, which beats every set event. Otherwise it is set by `ev_por`, `ev_wdt_clr` or `ev_sleep`, and otherwise it holds.
- R9: Power-down is cleared by `ev_sleep`, which beats `ev_por` and `ev_wdt_clr`. Otherwise it is set by `ev_por` or `ev_wdt_clr`, and otherwise it holds.
- R10: `result` follows the operands, op code and current carry combinationally, whether or not `op_valid` is high. With `op_valid` and `sw_we` low, flags 2..0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute strobe: update flags from this operation |
| op_sel | input | 3 | Operation code (0 add … 7 pass) |
| opnd_a | input | 8 | First operand / rotate source |
| opnd_b | input | 8 | Second operand |
| sw_we | input | 1 | Direct software write of the flag register |
| sw_wdata | input | 8 | Software write data |
| ev_por | input | 1 | Power-up event pulse |
| ev_wdt_clr | input | 1 | Watchdog-clear event pulse |
| ev_sleep | input | 1 | Sleep event pulse |
| ev_wdt_tmo | input | 1 | Watchdog time-out event pulse |
| result | output | 8 | ALU result |
| status | output | 8 | Status register |

## Verification
The checker watches the power-state transitions every cycle. This covers the clear-over-set priorities of both sticky flags and their holding when no event arrives. It also checks that the zero flag matches the previous result, that logic ops leave carry and digit carry unchanged, that software writes land in bits 2..0 only, and that bits 7..5 stay zero. The exact carry and digit-carry values of add, subtract and the rotates depend on operand arithmetic, so the bench's cycle-by-cycle model covers them. The bench also covers the boundary operands (overflow to zero, equal operands, nibble borrow) and a write colliding with an operation.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_RRC  = 3'd2,
        OP_RLC  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    // state encoding is {time-out, power-down}
    typedef enum logic [1:0] {
        PM_AWAKE      = 2'b11,
        PM_DOZING     = 2'b10,
        PM_EXPIRED    = 2'b01,
        PM_EXP_DOZING = 2'b00
    } pm_state_e;

    localparam int unsigned BIT_C  = 0;
    localparam int unsigned BIT_DC = 1;
    localparam int unsigned BIT_Z  = 2;
    localparam int unsigned BIT_PD = 3;
    localparam int unsigned BIT_TO = 4;
    localparam int unsigned NIB_W  = 4;
endpackage

// File: rtl/alu_flag_core.sv
module alu_flag_core
    import alu_flag_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter bit          ROT_SETS_Z = 1'b0
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              dc_out,
    output logic              upd_z,
    output logic              upd_dc,
    output logic              upd_c
);
    localparam int unsigned SUM_W = DATA_W + 1;
    localparam int unsigned NSUM_W = NIB_W + 1;

    alu_op_e          op;
    logic [SUM_W-1:0]  sum_add, sum_sub;
    logic [NSUM_W-1:0] nib_add, nib_sub;

    assign op = alu_op_e'(op_sel);

    assign sum_add = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign sum_sub = {1'b0, opnd_a} + {1'b0, ~opnd_b} + SUM_W'(1);
    assign nib_add = {1'b0, opnd_a[NIB_W-1:0]} + {1'b0, opnd_b[NIB_W-1:0]};
    assign nib_sub = {1'b0, opnd_a[NIB_W-1:0]} + {1'b0, ~opnd_b[NIB_W-1:0]} + NSUM_W'(1);

    always_comb begin
        res    = opnd_a;
        c_out  = c_in;
        dc_out = 1'b0;
        upd_z  = 1'b1;
        upd_dc = 1'b0;
        upd_c  = 1'b0;
        unique case (op)
            OP_ADD: begin
                res    = sum_add[DATA_W-1:0];
                c_out  = sum_add[DATA_W];
                dc_out = nib_add[NIB_W];
                upd_dc = 1'b1;
                upd_c  = 1'b1;
            end
            OP_SUB: begin
                res    = sum_sub[DATA_W-1:0];
                c_out  = sum_sub[DATA_W];
                dc_out = nib_sub[NIB_W];
                upd_dc = 1'b1;
                upd_c  = 1'b1;
            end
            OP_RRC: begin
                res   = {c_in, opnd_a[DATA_W-1:1]};
                c_out = opnd_a[0];
                upd_c = 1'b1;
                upd_z = ROT_SETS_Z;
            end
            OP_RLC: begin
                res   = {opnd_a[DATA_W-2:0], c_in};
                c_out = opnd_a[DATA_W-1];
                upd_c = 1'b1;
                upd_z = ROT_SETS_Z;
            end
            OP_AND:  res = opnd_a & opnd_b;
            OP_OR:   res = opnd_a | opnd_b;
            OP_XOR:  res = opnd_a ^ opnd_b;
            OP_PASS: res = opnd_a;
            default: res = opnd_a;
        endcase
    end
endmodule

// File: rtl/alu_flag_pm.sv
module alu_flag_pm
    import alu_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_por,
    input  logic ev_wdt_clr,
    input  logic ev_sleep,
    input  logic ev_wdt_tmo,
    output logic to_flag,
    output logic pd_flag
);
    pm_state_e state, state_nxt;
    logic      to_nxt, pd_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_AWAKE;
        else        state <= state_nxt;
    end

    // clear events beat set events; no event keeps the state
    always_comb begin
        to_nxt = to_flag;
        pd_nxt = pd_flag;
        if (ev_wdt_tmo)                          to_nxt = 1'b0;
        else if (ev_por || ev_wdt_clr || ev_sleep) to_nxt = 1'b1;
        if (ev_sleep)                            pd_nxt = 1'b0;
        else if (ev_por || ev_wdt_clr)           pd_nxt = 1'b1;
        state_nxt = pm_state_e'({to_nxt, pd_nxt});
    end

    always_comb begin
        unique case (state)
            PM_AWAKE:      begin to_flag = 1'b1; pd_flag = 1'b1; end
            PM_DOZING:     begin to_flag = 1'b1; pd_flag = 1'b0; end
            PM_EXPIRED:    begin to_flag = 1'b0; pd_flag = 1'b1; end
            PM_EXP_DOZING: begin to_flag = 1'b0; pd_flag = 1'b0; end
            default:       begin to_flag = 1'b1; pd_flag = 1'b1; end
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flag_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter bit          ROT_SETS_Z = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              sw_we,
    input  logic [7:0]        sw_wdata,
    input  logic              ev_por,
    input  logic              ev_wdt_clr,
    input  logic              ev_sleep,
    input  logic              ev_wdt_tmo,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        status
);
    logic z_q, dc_q, c_q;
    logic c_new, dc_new, upd_z, upd_dc, upd_c;
    logic to_flag, pd_flag;

    alu_flag_core #(.DATA_W(DATA_W), .ROT_SETS_Z(ROT_SETS_Z)) u_core (
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .c_in   (c_q),
        .res    (result),
        .c_out  (c_new),
        .dc_out (dc_new),
        .upd_z  (upd_z),
        .upd_dc (upd_dc),
        .upd_c  (upd_c)
    );

    alu_flag_pm u_pm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_por     (ev_por),
        .ev_wdt_clr (ev_wdt_clr),
        .ev_sleep   (ev_sleep),
        .ev_wdt_tmo (ev_wdt_tmo),
        .to_flag    (to_flag),
        .pd_flag    (pd_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z_q  <= 1'b0;
            dc_q <= 1'b0;
            c_q  <= 1'b0;
        end else if (sw_we) begin
            z_q  <= sw_wdata[BIT_Z];
            dc_q <= sw_wdata[BIT_DC];
            c_q  <= sw_wdata[BIT_C];
        end else if (op_valid) begin
            if (upd_z)  z_q  <= (result == '0);
            if (upd_dc) dc_q <= dc_new;
            if (upd_c)  c_q  <= c_new;
        end
    end

    always_comb begin
        status         = '0;
        status[BIT_TO] = to_flag;
        status[BIT_PD] = pd_flag;
        status[BIT_Z]  = z_q;
        status[BIT_DC] = dc_q;
        status[BIT_C]  = c_q;
    end
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_sel,
    input logic              sw_we,
    input logic [7:0]        sw_wdata,
    input logic              ev_por,
    input logic              ev_wdt_clr,
    input logic              ev_sleep,
    input logic              ev_wdt_tmo,
    input logic [DATA_W-1:0] result,
    input logic [7:0]        status
);
    logic any_ev;
    assign any_ev = ev_por | ev_wdt_clr | ev_sleep | ev_wdt_tmo;

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:5] == 3'b000);

    a_r2_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> status[2:0] == $past(sw_wdata[2:0]));

    a_r2_sw_no_pm: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !any_ev) |=> $stable(status[4:3]));

    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_we && (op_sel == 3'd0 || op_sel == 3'd1 || op_sel >= 3'd4))
        |=> status[2] == ($past(result) == '0));

    a_r7_logic_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_we && op_sel >= 3'd4) |=> $stable(status[1:0]));

    a_r8_tmo_clr: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_tmo |=> !status[4]);

    a_r8_to_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_wdt_tmo && (ev_por || ev_wdt_clr || ev_sleep)) |=> status[4]);

    a_r9_sleep_clr: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sleep |=> !status[3]);

    a_r9_pd_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_sleep && (ev_por || ev_wdt_clr)) |=> status[3]);

    a_r9_pm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> $stable(status[4:3]));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !sw_we) |=> $stable(status[2:0]));
endmodule

bind alu_flag_reg alu_flag_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .ev_por     (ev_por),
    .ev_wdt_clr (ev_wdt_clr),
    .ev_sleep   (ev_sleep),
    .ev_wdt_tmo (ev_wdt_tmo),
    .result     (result),
    .status     (status)
);

// File: tb/sim_alu_flag_reg.sv
module sim_alu_flag_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] opnd_a = 8'd0, opnd_b = 8'd0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_wdata = 8'd0;
    logic       ev_por = 1'b0, ev_wdt_clr = 1'b0, ev_sleep = 1'b0, ev_wdt_tmo = 1'b0;
    logic [7:0] result, status;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    // reference model state
    int m_to = 1, m_pd = 1, m_z = 0, m_dc = 0, m_c = 0;

    always #5 clk = ~clk;

    alu_flag_reg u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .ev_por(ev_por), .ev_wdt_clr(ev_wdt_clr), .ev_sleep(ev_sleep),
        .ev_wdt_tmo(ev_wdt_tmo), .result(result), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_status();
        return m_to * 16 + m_pd * 8 + m_z * 4 + m_dc * 2 + m_c;
    endfunction

    task automatic step(input string req, input bit v, input int op, input int a, input int b,
                        input bit we, input int wd,
                        input bit por, input bit clr, input bit slp, input bit tmo);
        int r, cn, dcn;
        @(negedge clk);
        op_valid = v; op_sel = op[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        sw_we = we; sw_wdata = wd[7:0];
        ev_por = por; ev_wdt_clr = clr; ev_sleep = slp; ev_wdt_tmo = tmo;
        cn = m_c; dcn = m_dc;
        case (op)
            0: begin r = a + b; cn = r / 256; dcn = ((a % 16) + (b % 16)) / 16; end
            1: begin r = a + (255 - b) + 1; cn = r / 256;
                     dcn = ((a % 16) + (15 - (b % 16)) + 1) / 16; end
            2: begin r = m_c * 128 + a / 2; cn = a % 2; end
            3: begin r = (a * 2) % 256 + m_c; cn = a / 128; end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            default: r = a;
        endcase
        r = r % 256;
        #1;
        check({req, "/R10 result"}, int'(result), r);
        @(posedge clk);
        if (we) begin
            m_z = (wd / 4) % 2; m_dc = (wd / 2) % 2; m_c = wd % 2;
        end else if (v) begin
            if (op != 2 && op != 3) m_z = (r == 0) ? 1 : 0;
            m_c = cn; m_dc = dcn;
        end
        if (tmo) m_to = 0; else if (por || clr || slp) m_to = 1;
        if (slp) m_pd = 0; else if (por || clr) m_pd = 1;
        #2;
        check({req, " status"}, int'(status), exp_status());
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                $display("FAIL watchdog: cycles %0d expected below 20000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset status", int'(status), 8'h18);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", int'(status), 8'h18);

        // R2: direct writes, upper bits ignored
        step("R2 write ff", 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0, 0);
        step("R2 write 00", 0, 0, 0, 0, 1, 8'h00, 0, 0, 0, 0);
        step("R2 write beats op", 1, 0, 8'hFF, 8'h01, 1, 8'h02, 0, 0, 0, 0);
        // R3 add
        step("R3 add nibble carry", 1, 0, 8'h0F, 8'h01, 0, 0, 0, 0, 0, 0);
        step("R3 add wrap zero", 1, 0, 8'hFF, 8'h01, 0, 0, 0, 0, 0, 0);
        step("R3 add msb only", 1, 0, 8'h80, 8'h80, 0, 0, 0, 0, 0, 0);
        // R4 subtract
        step("R4 sub 5-3", 1, 1, 5, 3, 0, 0, 0, 0, 0, 0);
        step("R4 sub 3-5 borrow", 1, 1, 3, 5, 0, 0, 0, 0, 0, 0);
        step("R4 sub nibble borrow", 1, 1, 8'h10, 8'h01, 0, 0, 0, 0, 0, 0);
        step("R4 sub equal", 1, 1, 7, 7, 0, 0, 0, 0, 0, 0);
        // R6 rotates, R5 zero kept
        step("R6 set c", 0, 0, 0, 0, 1, 8'h01, 0, 0, 0, 0);
        step("R6 rrc", 1, 2, 8'h02, 0, 0, 0, 0, 0, 0, 0);
        step("R5 rlc zero result keeps z", 1, 3, 8'h80, 0, 0, 0, 0, 0, 0, 0);
        step("R6 rlc carry in", 1, 3, 8'h41, 0, 0, 0, 0, 0, 0, 0);
        // R7 logic ops
        step("R7 set flags", 0, 0, 0, 0, 1, 8'h03, 0, 0, 0, 0);
        step("R7 and zero", 1, 4, 8'hF0, 8'h0F, 0, 0, 0, 0, 0, 0);
        step("R7 or", 1, 5, 8'hF0, 8'h0F, 0, 0, 0, 0, 0, 0);
        step("R7 xor zero", 1, 6, 8'h5A, 8'h5A, 0, 0, 0, 0, 0, 0);
        step("R7 pass", 1, 7, 8'h33, 8'h00, 0, 0, 0, 0, 0, 0);
        step("R10 idle", 0, 0, 8'h01, 8'h01, 0, 0, 0, 0, 0, 0);
        // R8 / R9 power flags
        step("R9 sleep", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R8 timeout", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R9 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R8 clear sets both", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step("R9 sleep beats clear", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        step("R8 timeout beats clear", 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        step("R8 timeout beats sleep", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        step("R8 por", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R2 write ignores pm bits", 0, 0, 0, 0, 1, 8'hE0, 0, 0, 0, 1);

        for (int i = 0; i < 400; i++) begin
            int ev;
            ev = $urandom % 16;
            step("RND", bit'($urandom % 2), int'($urandom % 8), int'($urandom % 256),
                 int'($urandom % 256), bit'(($urandom % 5) == 0), int'($urandom % 256),
                 ev == 1, ev == 2 || ev == 5, ev == 3 || ev == 5, ev == 4);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule